// File: doc/BRIEF.md
# Nibble-Coded 16-bit Multicycle Core

This block is a small processor that runs a fixed 16-bit instruction set out of a 256-word synchronous memory. It reaches that memory over an 8-bit address bus with separate read and write strobes. Every read returns its data one clock after the strobe, so the core spends one wait cycle on every read. This applies to instruction fetch and to data reads alike.

Each instruction word splits into four fields. Bits 15:12 hold the opcode. Bits 11:8 name the first register. Bits 7:0 hold either an immediate or a direct address, and instructions that take two registers read the second register from bits 7:4. The core holds sixteen 16-bit registers, an 8-bit program counter, an instruction register and a 16-bit output latch. Only the output latch is visible outside the core. Software moves data between memory and registers, adds, branches on a zero register, sends memory words to the output latch and finally halts.

Top module: `tiny16_core`

## Requirements
- R1: While reset is low, out_data and out_valid are 0, halted is 0 and mem_wr is 0. After reset is released, the first fetch reads address 0, and all registers and the program counter start at zero.
- R2: Every instruction begins with a fetch cycle (mem_rd=1, mem_addr=PC). A cycle with no strobe follows it. The instruction executes in the third cycle, and the program counter then points at the next word, wrapping at 8 bits.
- R3: Opcode 0x3 writes the zero-extended immediate in bits 7:0 into the register named by bits 11:8. It takes 3 cycles with no memory strobe in the execute cycle.
- R4: Opcode 0x0 asserts mem_rd at the address in bits 7:0 during execute. One cycle with no strobe follows, and the returned word is written to the register named by bits 11:8. The instruction takes 4 cycles.
- R5: Opcode 0x1 writes the register named by bits 11:8 to the address in bits 7:0. Opcode 0x2 writes the register named by bits 7:4 to the address given by the low byte of the register named by bits 11:8. Both assert mem_wr for one cycle during execute, and the next cycle is a fetch.
- R6: Opcode 0x4 sets the register named by bits 11:8 to its own value plus the register named by bits 7:4, modulo 2^16, with no memory strobe.
- R7: Opcode 0x6 loads the address in bits 7:0 into the program counter when the register named by bits 11:8 is zero. Otherwise execution falls through to the next word.
- R8: Opcode 0x7 reads the address in bits 7:0 with the same timing as R4. In the cycle after the wait cycle, out_valid is 1 for exactly one cycle and out_data shows the word read. out_data changes only together with out_valid.
- R9: Opcode 0xF stops the core. From the next cycle until reset, halted stays 1 and neither strobe is asserted.
- R10: Opcodes 0x5 and 0x8 to 0xE change nothing and take 3 cycles.
- R11: mem_rd and mem_wr are never high in the same cycle, and mem_rd is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is returned on mem_rdata one clock later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Registered read data from the memory |
| out_data | output | 16 | Output latch contents |
| out_valid | output | 1 | One-cycle pulse when out_data takes a new word |
| halted | output | 1 | High once the halt instruction has executed |

## Verification
The core is run with two programs.

The first program builds a seven-term Fibonacci sequence. It uses direct and register-indirect stores and a zero-test loop on a word that the program itself overwrites, so the branch is taken several times and then falls through. Errors in loop exit or in operand fields show up as a wrong output sequence.

The second program loads 0xFFFF and adds one to it. The result shows whether the add wraps to zero. A register-indirect store then uses only the low byte of a full register. The program also runs a not-taken branch, two undefined opcodes and a taken branch that skips a halt.

After each program halts, reset is applied again to check that the output latch and the halted flag clear.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_STIND = 4'h2,
        OP_LDIMM = 4'h3,
        OP_ADD   = 4'h4,
        OP_JZ    = 4'h6,
        OP_OUT   = 4'h7,
        OP_HALT  = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0,
        PH_FWAIT = 3'd1,
        PH_EXEC  = 3'd2,
        PH_MWAIT = 3'd3,
        PH_HALT  = 3'd4
    } phase_e;

endpackage

// File: rtl/tiny16_decode.sv
module tiny16_decode
    import tiny16_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int FLD_W  = 4,
    parameter int IMM_W  = 8
) (
    input  logic [INSN_W-1:0] insn,
    output op_e               op,
    output logic [FLD_W-1:0]  sel_a,
    output logic [FLD_W-1:0]  sel_b,
    output logic [IMM_W-1:0]  imm
);
    localparam int OP_LSB = INSN_W - FLD_W;
    localparam int A_LSB  = OP_LSB - FLD_W;
    localparam int B_LSB  = A_LSB - FLD_W;

    always_comb begin
        op    = op_e'(insn[INSN_W-1:OP_LSB]);
        sel_a = insn[OP_LSB-1:A_LSB];
        sel_b = insn[A_LSB-1:B_LSB];
        imm   = insn[IMM_W-1:0];
    end
endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile #(
    parameter int DATA_W = 16,
    parameter int REG_N  = 16,
    parameter int SEL_W  = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [SEL_W-1:0]  rd_sel_a,
    input  logic [SEL_W-1:0]  rd_sel_b,
    output logic [DATA_W-1:0] rd_val_a,
    output logic [DATA_W-1:0] rd_val_b
);
    logic [DATA_W-1:0] regs_d [REG_N];
    logic [DATA_W-1:0] regs_q [REG_N];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d[wr_sel] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_val_a = regs_q[rd_sel_a];
    assign rd_val_b = regs_q[rd_sel_b];
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
    import tiny16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int REG_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted
);
    localparam int SEL_W = $clog2(REG_N);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] obuf;
        logic              ovld;
        logic              halt;
    } core_t;

    core_t core_d, core_q;

    op_e               op;
    logic [SEL_W-1:0]  sel_a, sel_b;
    logic [ADDR_W-1:0] imm;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wd, val_a, val_b;

    tiny16_decode #(.INSN_W(DATA_W), .FLD_W(SEL_W), .IMM_W(ADDR_W)) u_decode (
        .insn  (core_q.ir),
        .op    (op),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .imm   (imm)
    );

    tiny16_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_sel   (sel_a),
        .wr_val   (rf_wd),
        .rd_sel_a (sel_a),
        .rd_sel_b (sel_b),
        .rd_val_a (val_a),
        .rd_val_b (val_b)
    );

    always_comb begin
        core_d      = core_q;
        core_d.ovld = 1'b0;
        mem_addr    = '0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_wdata   = '0;
        rf_we       = 1'b0;
        rf_wd       = '0;
        case (core_q.ph)
            PH_FETCH: begin
                mem_rd    = 1'b1;
                mem_addr  = core_q.pc;
                core_d.ph = PH_FWAIT;
            end
            PH_FWAIT: begin
                core_d.ir = mem_rdata;
                core_d.pc = core_q.pc + 1'b1;
                core_d.ph = PH_EXEC;
            end
            PH_EXEC: begin
                core_d.ph = PH_FETCH;
                case (op)
                    OP_LDIMM: begin
                        rf_we = 1'b1;
                        rf_wd = DATA_W'(imm);
                    end
                    OP_LOAD, OP_OUT: begin
                        mem_rd    = 1'b1;
                        mem_addr  = imm;
                        core_d.ph = PH_MWAIT;
                    end
                    OP_STORE: begin
                        mem_wr    = 1'b1;
                        mem_addr  = imm;
                        mem_wdata = val_a;
                    end
                    OP_STIND: begin
                        mem_wr    = 1'b1;
                        mem_addr  = val_a[ADDR_W-1:0];
                        mem_wdata = val_b;
                    end
                    OP_ADD: begin
                        rf_we = 1'b1;
                        rf_wd = val_a + val_b;
                    end
                    OP_JZ: begin
                        if (val_a == '0) begin
                            core_d.pc = imm;
                        end
                    end
                    OP_HALT: begin
                        core_d.ph   = PH_HALT;
                        core_d.halt = 1'b1;
                    end
                    default: ;
                endcase
            end
            PH_MWAIT: begin
                core_d.ph = PH_FETCH;
                if (op == OP_OUT) begin
                    core_d.obuf = mem_rdata;
                    core_d.ovld = 1'b1;
                end else begin
                    rf_we = 1'b1;
                    rf_wd = mem_rdata;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign out_data  = core_q.obuf;
    assign out_valid = core_q.ovld;
    assign halted    = core_q.halt;
endmodule

// File: rtl/tiny16_core_chk.sv
module tiny16_core_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              halted
);
    a_r11_no_rd_and_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r11_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    a_r5_store_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> mem_rd);

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r8_data_moves_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));
endmodule

bind tiny16_core tiny16_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tiny16_core_bench.sv
module tiny16_core_bench;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic        ov;
        logic [15:0] od;
        logic        hl;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [15:0] out_data;
    logic        out_valid, halted;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tiny16_core u_tiny16_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .out_data  (out_data),
        .out_valid (out_valid),
        .halted    (halted)
    );

    // memory model: reloaded from the image while reset is low
    logic [15:0] image [256];
    logic [15:0] ram   [256];
    logic [15:0] rdata_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= image[i];
            rdata_q <= '0;
        end else begin
            if (mem_wr && !mem_rd) ram[mem_addr] <= mem_wdata;
            if (mem_rd && !mem_wr) rdata_q <= ram[mem_addr];
        end
    end
    assign mem_rdata = rdata_q;

    // instruction-level reference model producing a per-cycle schedule
    exp_t        eq[$];
    string       tq[$];
    logic [15:0] rr [16];
    logic [15:0] rm [256];
    logic [15:0] rout, pval;
    logic        pend, hflag;

    task automatic push(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [15:0] wd, input string tag);
        exp_t e;
        string t;
        t = tag;
        e.rd = rd; e.wr = wr; e.addr = a; e.wdata = wd;
        e.ov = 1'b0;
        if (pend) begin
            rout = pval;
            e.ov = 1'b1;
            pend = 1'b0;
            t = {tag, "/R8"};
        end
        e.od = rout;
        e.hl = hflag;
        eq.push_back(e);
        tq.push_back(t);
    endtask

    task automatic build_schedule();
        int pc;
        logic [15:0] ins;
        logic [3:0] a, b;
        logic [7:0] imm;
        for (int i = 0; i < 16; i++) rr[i] = '0;
        for (int i = 0; i < 256; i++) rm[i] = image[i];
        pc = 0; rout = '0; pend = 1'b0; hflag = 1'b0; pval = '0;
        for (int n = 0; n < 400; n++) begin
            ins = rm[pc];
            a = ins[11:8]; b = ins[7:4]; imm = ins[7:0];
            push(1'b1, 1'b0, 8'(pc), '0, (n == 0) ? "R1" : "R2");
            push(1'b0, 1'b0, '0, '0, "R2");
            pc = (pc + 1) % 256;
            case (ins[15:12])
                4'h3: begin rr[a] = {8'h00, imm}; push(0, 0, '0, '0, "R3"); end
                4'h0: begin
                    push(1, 0, imm, '0, "R4"); push(0, 0, '0, '0, "R4");
                    rr[a] = rm[imm];
                end
                4'h1: begin push(0, 1, imm, rr[a], "R5"); rm[imm] = rr[a]; end
                4'h2: begin push(0, 1, rr[a][7:0], rr[b], "R5"); rm[rr[a][7:0]] = rr[b]; end
                4'h4: begin rr[a] = rr[a] + rr[b]; push(0, 0, '0, '0, "R6"); end
                4'h6: begin if (rr[a] == 16'h0) pc = imm; push(0, 0, '0, '0, "R7"); end
                4'h7: begin
                    push(1, 0, imm, '0, "R8"); push(0, 0, '0, '0, "R8");
                    pend = 1'b1; pval = rm[imm];
                end
                4'hF: begin
                    push(0, 0, '0, '0, "R9");
                    hflag = 1'b1;
                    for (int k = 0; k < 12; k++) push(0, 0, '0, '0, "R9");
                    break;
                end
                default: push(0, 0, '0, '0, "R10");
            endcase
        end
    endtask

    task automatic check_reset();
        n_vec++;
        if (out_data !== 16'h0 || out_valid !== 1'b0 || halted !== 1'b0 || mem_wr !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got od=%h ov=%b hl=%b wr=%b exp od=0000 ov=0 hl=0 wr=0",
                     out_data, out_valid, halted, mem_wr);
        end
    endtask

    task automatic run_program();
        exp_t e;
        string t;
        logic ok;
        build_schedule();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1 check_reset();
        @(negedge clk); #1 check_reset();
        @(negedge clk); rst_n = 1'b1; #1;
        while (eq.size() > 0) begin
            e = eq.pop_front();
            t = tq.pop_front();
            n_vec++;
            ok = (mem_rd === e.rd) && (mem_wr === e.wr) &&
                 (!(e.rd || e.wr) || mem_addr === e.addr) &&
                 (!e.wr || mem_wdata === e.wdata) &&
                 (out_valid === e.ov) && (out_data === e.od) && (halted === e.hl);
            if (!ok) begin
                n_bad++;
                $display("FAIL %s: got rd=%b wr=%b addr=%h wd=%h ov=%b od=%h hl=%b exp rd=%b wr=%b addr=%h wd=%h ov=%b od=%h hl=%b",
                         t, mem_rd, mem_wr, mem_addr, mem_wdata, out_valid, out_data, halted,
                         e.rd, e.wr, e.addr, e.wdata, e.ov, e.od, e.hl);
            end
            @(negedge clk); #1;
        end
    endtask

    task automatic clear_image();
        for (int i = 0; i < 256; i++) image[i] = 16'h0000;
    endtask

    initial begin
        // program A: seven Fibonacci terms into 0x40..0x46, then output them
        clear_image();
        image[0]  = 16'h3000; image[1]  = 16'h3101; image[2]  = 16'h3342;
        image[3]  = 16'h3501; image[4]  = 16'h1040; image[5]  = 16'h1141;
        image[6]  = 16'h1180; image[7]  = 16'h4100; image[8]  = 16'h0080;
        image[9]  = 16'h2310; image[10] = 16'h4350; image[11] = 16'h0646;
        image[12] = 16'h6606;
        for (int i = 0; i < 7; i++) image[13+i] = 16'h7040 + 16'(i);
        image[20] = 16'hF000;
        run_program();

        // program B: wrap-around add, low-byte indirect address, branches, undefined opcodes
        clear_image();
        image[0]  = 16'h0830; image[1]  = 16'h3901; image[2]  = 16'h2890;
        image[3]  = 16'h70FF; image[4]  = 16'h4890; image[5]  = 16'h1831;
        image[6]  = 16'h7031; image[7]  = 16'h6912; image[8]  = 16'h5000;
        image[9]  = 16'hE123; image[10] = 16'h6810; image[11] = 16'h7030;
        image[12] = 16'hF000; image[16] = 16'h7030; image[17] = 16'hF000;
        image[48] = 16'hFFFF;
        run_program();

        // reset after halt clears the latch and the halted flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1 check_reset();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL R2 watchdog: got no completion, exp halt within 100000 cycles");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule